// File: doc/BRIEF.md
# TLB Duplicate-Entry Scrubber

The scrubber is a sequencer that cleans up a set-associative translation buffer after an overlap fault, which is raised when a lookup matched more than one way. A single start pulse makes it walk the whole buffer. It goes through the sets in ascending order and reads every way of a set through a one-cycle-latency entry read port. It keeps a local copy of the first data word of each way. A set where no copy has its present bit set is passed over. In any other set, each pair of ways is compared on the page-number field only. For each pair that matches, the lower-numbered way is erased and its local copy is zeroed.

The translation storage lies outside the block. The block drives one linear entry index, computed as `set * WAYS + way`, together with a read strobe and an erase strobe. An erase writes zero to both data words of the entry. When the verbose input is high, every erase also raises a report pulse. The report carries the set, the erased way, the way it matched, and the erased word. A one-cycle done pulse marks the end of the walk.

Top module: `tlb_dup_scrub`

## Requirements
- R1: Out of reset, busy_o, done_o, ent_rd_o, ent_wr_o and dup_o are all low. While busy_o is low, no read or erase strobe is issued.
- R2: A start_i pulse seen while idle raises busy_o on the next cycle. Sets are then visited from 0 to SETS-1. In each set, ways 0 to WAYS-1 are read on consecutive cycles at index `set*WAYS+way`. Read data is taken from ent_rd_d0_i one cycle after the strobe.
- R3: No erase occurs until every way of the current set has been read. A set where none of the read words has bit PRES_BIT (8 by default) set produces no erase, even when the page numbers match.
- R4: A way whose stored word is all zero is never erased and never acts as the lower element of a pair.
- R5: Two ways match when bits [DW-1:PAGE_LSB] (31:13 by default) are equal. Differences in bits below PAGE_LSB do not prevent a match.
- R6: For a matching pair (i, n) with i < n, the erase targets way i at index `set*WAYS+i`. It is a one-cycle ent_wr_o strobe with both write words zero. Way n is left in place.
- R7: Once way i has been erased, its local copy takes no further part in comparisons. With three equal ways 0, 1 and 2, ways 0 and 1 are erased once each and way 2 survives.
- R8: With verbose_i high, each erase raises dup_o in the same cycle. The report carries dup_set_o = set, dup_way_a_o = erased way, dup_way_b_o = the matching higher way, and dup_d0_o = the erased word. With verbose_i low, erases still happen but dup_o stays low.
- R9: After the last set, done_o is high for exactly one cycle, in the same cycle that busy_o falls. A start_i pulse during a walk has no effect, so the buffer is read exactly SETS*WAYS times per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scrub pass (accepted only when idle) |
| verbose_i | input | 1 | Enables the duplicate report |
| busy_o | output | 1 | Scrub pass in progress |
| done_o | output | 1 | One-cycle pulse at end of pass |
| ent_idx_o | output | IDX_W | Linear entry index set*WAYS+way |
| ent_rd_o | output | 1 | Entry read strobe |
| ent_rd_d0_i | input | DW | First data word of the entry, valid the cycle after ent_rd_o |
| ent_wr_o | output | 1 | Entry erase strobe |
| ent_wr_d0_o | output | DW | Erase write data, word 0 (zero) |
| ent_wr_d1_o | output | DW | Erase write data, word 1 (zero) |
| dup_o | output | 1 | Duplicate report pulse |
| dup_set_o | output | SET_W | Set of the duplicate |
| dup_way_a_o | output | WAY_W | Erased (lower) way |
| dup_way_b_o | output | WAY_W | Matching higher way |
| dup_d0_o | output | DW | Word 0 of the erased entry |

## Verification
The assertions assume three things about the environment. The storage returns read data exactly one cycle after the strobe. Nothing else changes the storage during a pass. verbose_i holds steady while busy_o is high, so the report gating can be related directly to the erase strobe. The bench models the storage as a registered array that is written only through the erase port. It loads new contents and changes verbose_i only while the block is idle. It sends start_i as a single-cycle pulse, plus one deliberate extra pulse in the middle of a pass.

// File: rtl/tlb_scrub_pkg.sv
package tlb_scrub_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_SETTLE,
    S_CHECK,
    S_PAIR,
    S_NEXT
  } scrub_st_e;
endpackage

// File: rtl/scrub_way_buf.sv
module scrub_way_buf #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned PRES_BIT = 8,
  parameter int unsigned WAY_W    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_i,
  input  logic [WAY_W-1:0]          cap_way_i,
  input  logic [DW-1:0]             cap_data_i,
  input  logic                      clr_i,
  input  logic [WAY_W-1:0]          clr_way_i,
  output logic [WAYS-1:0][DW-1:0]   ent_o,
  output logic                      any_pres_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_o[g] <= '0;
      else if (cap_i && cap_way_i == WAY_W'(g)) ent_o[g] <= cap_data_i;
      else if (clr_i && clr_way_i == WAY_W'(g)) ent_o[g] <= '0;
    end
  end

  always_comb begin
    any_pres_o = 1'b0;
    for (int w = 0; w < WAYS; w++) any_pres_o = any_pres_o | ent_o[w][PRES_BIT];
  end
endmodule

// File: rtl/scrub_pair_cmp.sv
module scrub_pair_cmp #(
  parameter int unsigned DW       = 32,
  parameter int unsigned PAGE_LSB = 13
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          hit_o
);
  // cleared / empty lower entry never matches
  assign hit_o = (lo_i != '0) && (lo_i[DW-1:PAGE_LSB] == hi_i[DW-1:PAGE_LSB]);
endmodule

// File: rtl/tlb_dup_scrub.sv
module tlb_dup_scrub
  import tlb_scrub_pkg::*;
#(
  parameter int unsigned SETS     = 8,
  parameter int unsigned WAYS     = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned PAGE_LSB = 13,
  parameter int unsigned PRES_BIT = 8,
  localparam int unsigned SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned IDX_W   = (SETS * WAYS > 1) ? $clog2(SETS * WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              verbose_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  ent_idx_o,
  output logic              ent_rd_o,
  input  logic [DW-1:0]     ent_rd_d0_i,
  output logic              ent_wr_o,
  output logic [DW-1:0]     ent_wr_d0_o,
  output logic [DW-1:0]     ent_wr_d1_o,
  output logic              dup_o,
  output logic [SET_W-1:0]  dup_set_o,
  output logic [WAY_W-1:0]  dup_way_a_o,
  output logic [WAY_W-1:0]  dup_way_b_o,
  output logic [DW-1:0]     dup_d0_o
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);
  localparam logic [WAY_W-1:0] PEN_WAY  = WAY_W'((WAYS > 1) ? WAYS - 2 : 0);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);
  localparam logic [IDX_W-1:0] WAYS_I   = IDX_W'(WAYS);

  scrub_st_e           st_q;
  logic [SET_W-1:0]    set_q;
  logic [WAY_W-1:0]    rd_way_q, cap_way_q, i_q, n_q, way_sel;
  logic                cap_q, done_q;
  logic [WAYS-1:0][DW-1:0] ent;
  logic                any_pres, pair_hit, hit;

  scrub_way_buf #(
    .WAYS(WAYS), .DW(DW), .PRES_BIT(PRES_BIT), .WAY_W(WAY_W)
  ) buf_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_q),
    .cap_way_i  (cap_way_q),
    .cap_data_i (ent_rd_d0_i),
    .clr_i      (hit),
    .clr_way_i  (i_q),
    .ent_o      (ent),
    .any_pres_o (any_pres)
  );

  scrub_pair_cmp #(.DW(DW), .PAGE_LSB(PAGE_LSB)) cmp_i (
    .lo_i  (ent[i_q]),
    .hi_i  (ent[n_q]),
    .hit_o (pair_hit)
  );

  assign hit = (st_q == S_PAIR) && pair_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      set_q     <= '0;
      rd_way_q  <= '0;
      cap_way_q <= '0;
      cap_q     <= 1'b0;
      i_q       <= '0;
      n_q       <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      cap_q     <= (st_q == S_READ);
      cap_way_q <= rd_way_q;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          set_q    <= '0;
          rd_way_q <= '0;
          st_q     <= S_READ;
        end
        S_READ: begin
          if (rd_way_q == LAST_WAY) st_q <= S_SETTLE;
          else rd_way_q <= rd_way_q + WAY_W'(1);
        end
        S_SETTLE: st_q <= S_CHECK;  // last read word lands in buffer
        S_CHECK: begin
          i_q  <= '0;
          n_q  <= WAY_W'(1);
          st_q <= (any_pres && WAYS > 1) ? S_PAIR : S_NEXT;
        end
        S_PAIR: begin
          if (n_q == LAST_WAY) begin
            if (i_q == PEN_WAY) st_q <= S_NEXT;
            else begin
              i_q <= i_q + WAY_W'(1);
              n_q <= i_q + WAY_W'(2);
            end
          end else begin
            n_q <= n_q + WAY_W'(1);
          end
        end
        S_NEXT: begin
          rd_way_q <= '0;
          if (set_q == LAST_SET) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            set_q <= set_q + SET_W'(1);
            st_q  <= S_READ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign way_sel     = (st_q == S_PAIR) ? i_q : rd_way_q;
  assign ent_idx_o   = IDX_W'(set_q) * WAYS_I + IDX_W'(way_sel);
  assign ent_rd_o    = (st_q == S_READ);
  assign ent_wr_o    = hit;
  assign ent_wr_d0_o = '0;
  assign ent_wr_d1_o = '0;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign dup_o       = hit && verbose_i;
  assign dup_set_o   = set_q;
  assign dup_way_a_o = i_q;
  assign dup_way_b_o = n_q;
  assign dup_d0_o    = ent[i_q];
endmodule

// File: rtl/tlb_scrub_chk.sv
module tlb_scrub_chk #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned SET_W = 3,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             verbose_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] ent_idx_o,
  input logic             ent_rd_o,
  input logic             ent_wr_o,
  input logic             dup_o,
  input logic [SET_W-1:0] dup_set_o,
  input logic [WAY_W-1:0] dup_way_a_o,
  input logic [WAY_W-1:0] dup_way_b_o,
  input logic [DW-1:0]    dup_d0_o
);
  localparam logic [IDX_W:0] TOTAL = (IDX_W+1)'(SETS * WAYS);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ent_rd_o && !ent_wr_o));
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_rd_consec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_rd_o && $past(ent_rd_o)) |-> ent_idx_o == $past(ent_idx_o) + IDX_W'(1));
  assert_idx_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_rd_o || ent_wr_o) |-> {1'b0, ent_idx_o} < TOTAL);
  assert_rd_wr_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_rd_o |-> !ent_wr_o);
  assert_dup_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_o |-> dup_d0_o != '0);
  assert_erase_lower_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_o |-> dup_way_a_o < dup_way_b_o);
  assert_erase_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_o |-> ent_idx_o == IDX_W'(dup_set_o) * IDX_W'(WAYS) + IDX_W'(dup_way_a_o));
  assert_dup_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_o |-> (verbose_i && ent_wr_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind tlb_dup_scrub tlb_scrub_chk #(
  .SETS(SETS), .WAYS(WAYS), .DW(DW), .SET_W(SET_W), .WAY_W(WAY_W), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/tlb_dup_scrub_tb_top.sv
module tlb_dup_scrub_tb_top;
  localparam int SETS = 8, WAYS = 4, DW = 32, PAGE_LSB = 13, PRES_BIT = 8;
  localparam int TOTAL = SETS * WAYS;
  localparam int SET_W = 3, WAY_W = 2, IDX_W = 5;

  typedef struct {
    int          idx;
    int          set;
    int          wa;
    int          wb;
    logic [31:0] d0;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verb = 1'b0;
  logic busy, done, rd, wr, dup;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0] rdata = '0, wd0, wd1, dup_d0;
  logic [SET_W-1:0] dup_set;
  logic [WAY_W-1:0] dup_wa, dup_wb;

  logic [31:0] mem_d0 [TOTAL];
  logic [31:0] mem_d1 [TOTAL];
  logic [31:0] exp_d0 [TOTAL];
  logic [31:0] exp_d1 [TOTAL];
  exp_t sb_q[$];
  int total = 0, bad = 0, rd_exp = 0;

  always #2 clk = ~clk;

  tlb_dup_scrub #(.SETS(SETS), .WAYS(WAYS), .DW(DW), .PAGE_LSB(PAGE_LSB), .PRES_BIT(PRES_BIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .verbose_i(verb),
    .busy_o(busy), .done_o(done), .ent_idx_o(idx), .ent_rd_o(rd),
    .ent_rd_d0_i(rdata), .ent_wr_o(wr), .ent_wr_d0_o(wd0), .ent_wr_d1_o(wd1),
    .dup_o(dup), .dup_set_o(dup_set), .dup_way_a_o(dup_wa), .dup_way_b_o(dup_wb),
    .dup_d0_o(dup_d0)
  );

  // storage model: registered read, erase writes both words
  always @(posedge clk) begin
    if (rd) rdata <= mem_d0[idx];
    if (wr) begin
      mem_d0[idx] <= wd0;
      mem_d1[idx] <= wd1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each erase
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd) begin
        chk(idx == IDX_W'(rd_exp), "R2 read index", 32'(idx), 32'(rd_exp));
        rd_exp++;
      end
      if (wr) begin
        chk(rd_exp % WAYS == 0, "R3 erase before set fully read", 32'(rd_exp), 32'(TOTAL));
        chk(wd0 == 0 && wd1 == 0, "R6 erase data zero", wd0 | wd1, 32'h0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R6 unexpected erase", 32'(idx), 32'hffff_ffff);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(idx == IDX_W'(e.idx), "R6 erase index", 32'(idx), 32'(e.idx));
          chk(dup == verb, "R8 report gating", 32'(dup), 32'(verb));
          if (dup) begin
            chk(dup_set == SET_W'(e.set), "R8 report set", 32'(dup_set), 32'(e.set));
            chk(dup_wa == WAY_W'(e.wa), "R8 report erased way", 32'(dup_wa), 32'(e.wa));
            chk(dup_wb == WAY_W'(e.wb), "R8 report other way", 32'(dup_wb), 32'(e.wb));
            chk(dup_d0 == e.d0, "R8 report word", dup_d0, e.d0);
          end
        end
      end else if (dup) begin
        chk(1'b0, "R8 report without erase", 32'(dup), 32'h0);
      end
    end
  end

  function automatic logic [31:0] mk(input int page, input int lo);
    return (32'(page) << PAGE_LSB) | 32'h100 | 32'(lo);
  endfunction

  // driver: load storage, compute expected erases
  task automatic load_and_model();
    logic [31:0] b [WAYS];
    for (int k = 0; k < TOTAL; k++) begin
      mem_d0[k] = 32'h0;
      mem_d1[k] = 32'h1000 + 32'(k);
    end
    mem_d0[0]  = mk(4, 1);  mem_d0[1]  = mk(4, 8'h55); mem_d0[2] = mk(12, 0);          // R5
    mem_d0[4]  = (32'd5 << PAGE_LSB) | 3; mem_d0[5] = (32'd5 << PAGE_LSB) | 4;          // R3
    mem_d0[8]  = mk(6, 1);  mem_d0[9]  = mk(6, 2); mem_d0[10] = mk(6, 3); mem_d0[11] = mk(11, 0); // R7
    mem_d0[13] = mk(0, 2);  mem_d0[14] = mk(9, 0); mem_d0[15] = mk(10, 0);              // R4
    mem_d0[16] = mk(1, 0);  mem_d0[17] = mk(2, 0); mem_d0[18] = mk(3, 0); mem_d0[19] = mk(4, 0);
    mem_d0[20] = mk(8, 0);  mem_d0[22] = mk(7, 1); mem_d0[23] = mk(7, 2);
    mem_d0[28] = mk(3, 0);  mem_d0[29] = mk(13, 1); mem_d0[30] = mk(14, 0); mem_d0[31] = mk(13, 2);
    for (int k = 0; k < TOTAL; k++) begin
      exp_d0[k] = mem_d0[k];
      exp_d1[k] = mem_d1[k];
    end
    sb_q.delete();
    for (int s = 0; s < SETS; s++) begin
      bit pres = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        b[w] = mem_d0[s*WAYS+w];
        pres |= b[w][PRES_BIT];
      end
      if (!pres) continue;
      for (int i = 0; i < WAYS; i++)
        for (int n = i + 1; n < WAYS; n++)
          if (b[i] != 0 && b[i][31:PAGE_LSB] == b[n][31:PAGE_LSB]) begin
            exp_t e;
            e.idx = s*WAYS+i; e.set = s; e.wa = i; e.wb = n; e.d0 = b[i];
            sb_q.push_back(e);
            b[i] = 0;
            exp_d0[s*WAYS+i] = 0;
            exp_d1[s*WAYS+i] = 0;
          end
    end
  endtask

  task automatic run_pass(input logic v);
    int cyc = 0;
    bit seen = 1'b0;
    @(negedge clk);
    verb = v;
    load_and_model();
    rd_exp = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'h1);
    repeat (10) @(negedge clk);
    start = 1'b1;                       // ignored while busy
    @(negedge clk);
    start = 1'b0;
    while (!seen && cyc < 5000) begin
      if (done) seen = 1'b1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(seen, "R9 done reached", 32'(cyc), 32'h0);
    chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 32'h0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 32'(done), 32'h0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R9 start during pass ignored", 32'(busy), 32'h0);
    chk(rd_exp == TOTAL, "R9 read count", 32'(rd_exp), 32'(TOTAL));
    chk(sb_q.size() == 0, "R6 missing erases", 32'(sb_q.size()), 32'h0);
    for (int k = 0; k < TOTAL; k++) begin
      chk(mem_d0[k] == exp_d0[k], "R3/R4/R5/R6/R7 word0", mem_d0[k], exp_d0[k]);
      chk(mem_d1[k] == exp_d1[k], "R6 word1", mem_d1[k], exp_d1[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd && !wr && !dup, "R1 reset state",
        {27'h0, busy, done, rd, wr, dup}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd && !wr, "R1 idle after reset", {29'h0, busy, rd, wr}, 32'h0);
    run_pass(1'b1);
    run_pass(1'b0);   // R8: no reports with verbose low
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule